// File: doc/BRIEF.md
# I/O Doorbell Register Window

This block decodes a 32-byte window of byte-wide I/O space. The window starts at a base address, and a decode enable turns it on. A configuration block that sits beside it supplies both. The first four bytes of the window read back as fixed identification bytes. The next two bytes mirror the interrupt line and interrupt pin values that the configuration block holds.

Offset 6 is a software doorbell. Any write to it sets a sticky flag, and the flag drives a level interrupt. A read of the same offset returns the flag and clears it in the same access, so the reader learns the state and drops the request in one step.

Read data is combinational while the read strobe is high. The flag, and with it the interrupt output, changes on the clock edge that ends the access.

Top module: `io_doorbell`

## Requirements
- R1: After reset `irqOut` is 0.
- R2: The window is hit only when `decodeEn` is 1 and `baseAddr <= ioAddr <= baseAddr+31`. A read outside the window, or made while decode is off, returns 0xFF. A write or read there leaves `irqOut` unchanged.
- R3: Reads of in-window offsets 0, 1, 2 and 3 return 0x1A, 0x07, 0x0B and 0xAB respectively.
- R4: A read of offset 4 returns `intLine`, and a read of offset 5 returns `intPin`.
- R5: A read of offset 6 returns 0x00 when the flag is clear and 0x01 when it is set. `irqOut` is 0 after the clock edge that ends a read of offset 6 made with no write.
- R6: A write of any value to offset 6 makes `irqOut` 1 after that clock edge. A further write while the flag is set leaves it set.
- R7: Writes to in-window offsets other than 6 leave `irqOut` unchanged.
- R8: Reads of in-window offsets 7 to 31 return 0x00.
- R9: When a read and a write to offset 6 happen in the same cycle, the read returns the flag as it was, and the flag is set afterwards.
- R10: `irqOut` comes from a register. It changes only on the clock edge after the access that sets or clears it, and it stays set until a read of offset 6 or a reset.
- R11: While `ioRd` is 0, `ioRdData` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decodeEn | input | 1 | I/O decode enable from configuration |
| baseAddr | input | ADDR_W | Window base address from configuration |
| ioAddr | input | ADDR_W | I/O byte address |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioWrData | input | 8 | Write data (value ignored) |
| intLine | input | 8 | Interrupt line value from configuration |
| intPin | input | 8 | Interrupt pin value from configuration |
| ioRdData | output | 8 | Read data, valid while `ioRd` is high |
| irqOut | output | 1 | Level interrupt, equal to the doorbell flag |

## Verification
Reads sweep every address from two below the base to two past the window. The sweep runs for an aligned base, an odd unaligned base and a high base, each with decode on and off. This separates the edges of the range compare, the enable gating and every entry of the read mux.

A write sweep covers every non-doorbell offset, with the flag both clear and set. It shows that no other offset touches the flag.

Doorbell sequences cover these cases:
- set, repeated set, read-clear and read while clear;
- out-of-window and disabled doorbell attempts;
- a simultaneous read and write, which separates the write-wins order from the read-wins order.

// File: rtl/io_doorbell_pkg.sv
package io_doorbell_pkg;
  localparam int WIN_BYTES = 32;
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam logic [OFF_W-1:0] DOOR_OFF = OFF_W'(6);
  localparam logic [7:0] ID_B0 = 8'h1A;
  localparam logic [7:0] ID_B1 = 8'h07;
  localparam logic [7:0] ID_B2 = 8'h0B;
  localparam logic [7:0] ID_B3 = 8'hAB;
  localparam logic [7:0] MISS_DATA = 8'hFF;

  typedef struct packed {
    logic rdHit;
    logic rdDoor;
    logic wrDoor;
    logic [OFF_W-1:0] offset;
  } ctrlStrobes_t;
endpackage

// File: rtl/io_doorbell_ctrl.sv
module io_doorbell_ctrl
  import io_doorbell_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              decodeEn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  output ctrlStrobes_t      strb
);
  localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WIN_BYTES);

  logic [ADDR_W-1:0] delta;
  logic inWindow;
  logic isDoor;

  always_comb begin
    delta    = ioAddr - baseAddr;
    inWindow = decodeEn && (ioAddr >= baseAddr) && (delta < WIN_LIMIT);
    isDoor   = inWindow && (delta[OFF_W-1:0] == DOOR_OFF);
    strb.rdHit  = ioRd && inWindow;
    strb.rdDoor = ioRd && isDoor;
    strb.wrDoor = ioWr && isDoor;
    strb.offset = delta[OFF_W-1:0];
  end
endmodule

// File: rtl/io_doorbell_dp.sv
module io_doorbell_dp
  import io_doorbell_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic [7:0]   intLine,
  input  logic [7:0]   intPin,
  output logic [7:0]   rdData,
  output logic         doorFlag
);
  logic flagNext;

  always_comb begin
    flagNext = doorFlag;
    if (strb.rdDoor) flagNext = 1'b0;
    if (strb.wrDoor) flagNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doorFlag <= 1'b0;
    else       doorFlag <= flagNext;
  end

  always_comb begin
    rdData = MISS_DATA;
    if (strb.rdHit) begin
      case (strb.offset)
        OFF_W'(0): rdData = ID_B0;
        OFF_W'(1): rdData = ID_B1;
        OFF_W'(2): rdData = ID_B2;
        OFF_W'(3): rdData = ID_B3;
        OFF_W'(4): rdData = intLine;
        OFF_W'(5): rdData = intPin;
        DOOR_OFF:  rdData = {7'b0, doorFlag};
        default:   rdData = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/io_doorbell.sv
module io_doorbell
  import io_doorbell_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decodeEn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWrData,
  input  logic [7:0]        intLine,
  input  logic [7:0]        intPin,
  output logic [7:0]        ioRdData,
  output logic              irqOut
);
  ctrlStrobes_t strb;
  logic unusedWr;

  assign unusedWr = ^ioWrData;

  io_doorbell_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .decodeEn(decodeEn), .baseAddr(baseAddr), .ioAddr(ioAddr),
    .ioRd(ioRd), .ioWr(ioWr), .strb(strb)
  );

  io_doorbell_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .intLine(intLine),
    .intPin(intPin), .rdData(ioRdData), .doorFlag(irqOut)
  );
endmodule

// File: rtl/io_doorbell_chk.sv
module io_doorbell_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              decodeEn,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [7:0]        ioRdData,
  input logic              irqOut
);
  logic doorAddr;
  assign doorAddr = decodeEn && (ioAddr == baseAddr + ADDR_W'(6));

  a_r2_disabled_miss: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !decodeEn) |-> ioRdData == 8'hFF);
  a_r2_disabled_stable: assert property (@(posedge clk) disable iff (!rstN)
    !decodeEn |=> $stable(irqOut));
  a_r5_read_flag: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && doorAddr) |-> ioRdData == {7'b0, irqOut});
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && doorAddr) |=> !irqOut);
  a_r6_write_sets: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && doorAddr) |=> irqOut);
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ioRd && !ioWr) |=> $stable(irqOut));
  a_r11_idle_ff: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> ioRdData == 8'hFF);
endmodule

bind io_doorbell io_doorbell_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .decodeEn(decodeEn), .baseAddr(baseAddr),
  .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .ioRdData(ioRdData),
  .irqOut(irqOut)
);

// File: tb/io_doorbell_bench.sv
module io_doorbell_bench;
  logic clk = 0, rstN = 0, decodeEn = 0, ioRd = 0, ioWr = 0;
  logic [15:0] baseAddr = 16'h0100, ioAddr = 0;
  logic [7:0] ioWrData = 0, intLine = 8'h0B, intPin = 8'h01;
  logic [7:0] ioRdData;
  logic irqOut;
  int checks = 0, fails = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  io_doorbell u_io_doorbell (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic access(logic rd, logic wr, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    ioRd = rd; ioWr = wr; ioAddr = a; ioWrData = d;
    #2 got = ioRdData;
    @(negedge clk);
    ioRd = 0; ioWr = 0;
  endtask

  function automatic logic [7:0] expRead(logic en, logic [15:0] b, logic [15:0] a, logic f);
    int off;
    off = int'(a) - int'(b);
    if (!en || off < 0 || off > 31) return 8'hFF;
    case (off)
      0: return 8'h1A;
      1: return 8'h07;
      2: return 8'h0B;
      3: return 8'hAB;
      4: return intLine;
      5: return intPin;
      6: return {7'b0, f};
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] bases [3];
    bases[0] = 16'h0100; bases[1] = 16'h0013; bases[2] = 16'h2FE0;
    repeat (3) @(negedge clk);
    chk("R1 reset irq", {7'b0, irqOut}, 8'h00);
    rstN = 1;
    @(negedge clk);
    chk("R11 idle data", ioRdData, 8'hFF);
    // R2 R3 R4 R8: read sweep, flag clear
    for (int bi = 0; bi < 3; bi++) begin
      baseAddr = bases[bi];
      intLine = 8'h10 + 8'(bi); intPin = 8'h01 + 8'(bi);
      for (int en = 0; en < 2; en++) begin
        decodeEn = en[0];
        for (int k = -2; k < 34; k++) begin
          logic [15:0] a;
          a = 16'(int'(baseAddr) + k);
          access(1, 0, a, 0);
          chk("R2/R3/R4/R8 read sweep", got, expRead(decodeEn, baseAddr, a, 0));
        end
      end
    end
    decodeEn = 1; baseAddr = 16'h0100;
    // R7: writes to other offsets leave flag clear
    for (int k = 0; k < 32; k++) begin
      if (k == 6) continue;
      access(0, 1, 16'h0100 + 16'(k), 8'h5A);
      chk("R7 other write clear", {7'b0, irqOut}, 8'h00);
    end
    // R5: read while clear
    access(1, 0, 16'h0106, 0);
    chk("R5 read clear flag", got, 8'h00);
    // R2: out-of-window and disabled writes
    access(0, 1, 16'h00FA, 0);
    chk("R2 outside write", {7'b0, irqOut}, 8'h00);
    decodeEn = 0;
    access(0, 1, 16'h0106, 0);
    chk("R2 disabled write", {7'b0, irqOut}, 8'h00);
    decodeEn = 1;
    // R6 R10: set, timing
    @(negedge clk);
    ioWr = 1; ioAddr = 16'h0106; ioWrData = 8'h00;
    #2 chk("R10 irq not before edge", {7'b0, irqOut}, 8'h00);
    @(negedge clk); ioWr = 0;
    chk("R6 write sets", {7'b0, irqOut}, 8'h01);
    access(0, 1, 16'h0106, 8'hFF);
    chk("R6 second write holds", {7'b0, irqOut}, 8'h01);
    for (int k = 0; k < 32; k++) begin
      if (k == 6) continue;
      access(0, 1, 16'h0100 + 16'(k), 8'hA5);
      chk("R7 other write set", {7'b0, irqOut}, 8'h01);
      access(1, 0, 16'h0100 + 16'(k), 0);
      chk("R10 other read holds", {7'b0, irqOut}, 8'h01);
    end
    decodeEn = 0;
    access(1, 0, 16'h0106, 0);
    chk("R2 disabled read data", got, 8'hFF);
    chk("R2 disabled read keeps", {7'b0, irqOut}, 8'h01);
    decodeEn = 1;
    repeat (5) @(negedge clk);
    chk("R10 level held", {7'b0, irqOut}, 8'h01);
    access(1, 0, 16'h0106, 0);
    chk("R5 read set flag", got, 8'h01);
    chk("R5 read clears", {7'b0, irqOut}, 8'h00);
    // R9: simultaneous read+write
    access(1, 1, 16'h0106, 0);
    chk("R9 rd data old flag", got, 8'h00);
    chk("R9 write wins", {7'b0, irqOut}, 8'h01);
    access(1, 1, 16'h0106, 0);
    chk("R9 rd data set", got, 8'h01);
    chk("R9 write wins again", {7'b0, irqOut}, 8'h01);
    // R1: reset clears
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    chk("R1 reset clears", {7'b0, irqOut}, 8'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule